// File: doc/BRIEF.md
# Transmit Retry and Fault Tracker

This block supervises the transmission of one packet from the moment the host side hands it over until it is either sent or given up. It decides when the line may be driven: it waits while the medium is busy, and it waits a backoff interval after each early collision. It counts collisions against a retry limit and recognises the two faults that must never be retried, a collision after the slot time and a loss of carrier during its own transmission. The result is a small set of status flags and a collision-distance count, ready to be written back into the packet's descriptor.

The backoff length is not generated here. A pseudo-random source outside the block presents a value on `backoffVal`, and the tracker samples it at the collision that starts the backoff. The surrounding MAC drives bits onto the line while `xmitOn` is high, and it reports the end of the frame, collisions, the slot-time boundary and the carrier state back to the tracker.

Top module: `txRetryTracker`

## Requirements
- R1: After reset every output is low. When `frameEnd` is seen in a transmit cycle with no collision and with carrier present, `doneTx` is high for exactly one cycle starting one cycle later. `doneTx` and `abortTx` are never high together.
- R2: If `netBusy` is high when a packet starts, or when a backoff ends, the block waits with `xmitOn` low until `netBusy` is seen low, and it sets `stDeferred`.
- R3: A collision with `slotDone` low, while attempts remain, makes `retryReq` high for one cycle and loads `backoffVal`. `xmitOn` then stays low for `backoffVal`+1 cycles before the next attempt begins.
- R4: On success, `stOneRetry` is set if exactly one collision came before it, and `stMultiRetry` is set if two or more did. The two flags are never set together.
- R5: The 16th early collision of one packet ends it with `abortTx` and `stRetryFail` set, and no retry request.
- R6: With `noRetry` high, the first early collision ends the packet with `abortTx` and `stRetryFail` set.
- R7: A collision seen while `slotDone` is high sets `stLateColl` and aborts the packet with no retry.
- R8: `carrierOk` seen low in a transmit cycle with no collision sets `stCarrierLost` and aborts the packet with no retry.
- R9: `stTdr` holds the number of transmit cycles of the current attempt that came before its early collision. The first cycle of each attempt counts as 0, and the count restarts at every attempt. A late collision leaves `stTdr` unchanged.
- R10: The collision-distance count saturates at 1023 and does not wrap.
- R11: The status outputs stay frozen after done or abort. They are cleared only when `txStart` is accepted while the block is idle. A `txStart` during an active packet is ignored.
- R12: Events that arrive in the same transmit cycle are handled by priority: collision first, then carrier loss, then frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txStart | input | 1 | New packet ready; accepted only when idle |
| collision | input | 1 | Collision detected on the medium |
| carrierOk | input | 1 | Carrier present |
| netBusy | input | 1 | Medium occupied by another station |
| slotDone | input | 1 | Slot time of the current attempt has elapsed |
| frameEnd | input | 1 | Last bit of the frame sent |
| noRetry | input | 1 | Give up after the first collision |
| backoffVal | input | 8 | External random backoff length in cycles |
| xmitOn | output | 1 | The MAC may drive the line |
| retryReq | output | 1 | One-cycle pulse: backoff started, a retry follows |
| abortTx | output | 1 | One-cycle pulse: packet given up |
| doneTx | output | 1 | One-cycle pulse: packet sent |
| stRetryFail | output | 1 | Retry limit exhausted |
| stLateColl | output | 1 | Collision after slot time |
| stCarrierLost | output | 1 | Carrier dropped during transmit |
| stDeferred | output | 1 | Had to wait for a busy medium |
| stOneRetry | output | 1 | Sent after exactly one collision |
| stMultiRetry | output | 1 | Sent after two or more collisions |
| stTdr | output | 10 | Cycles from attempt start to collision |

## Verification
The bench goes after the edges of the retry limit: 15 collisions followed by success, exactly 16, and a single collision with `noRetry` set. An off-by-one limit shows up as a stray retry request or an early abort. It drives collision-distance offsets past 1023 to catch a counter that wraps, and it follows a long first attempt with a short second one to expose a counter that is not restarted. It checks backoff lengths of zero and above, because a wrong reload or compare shifts when `xmitOn` comes back. Same-cycle pile-ups of collision, carrier loss and frame end, together with a `txStart` pulsed mid-packet, catch wrong priority and status that is cleared at the wrong time.

// File: rtl/txrt_pkg.sv
package txrt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_DEFER   = 2'd1,
    ST_XMIT    = 2'd2,
    ST_BACKOFF = 2'd3
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;       // new packet accepted
    logic setDef;       // entered deferral
    logic restartTdr;   // attempt begins next cycle
    logic tick;         // current cycle is a transmit cycle
    logic collide;      // early collision: count and capture distance
    logic setLcol;
    logic setLcar;
    logic setRtry;
    logic finish;       // success: latch retry summary
    logic loadBackoff;
  } dpCtl_t;

endpackage

// File: rtl/txrt_data.sv
module txrt_data
  import txrt_pkg::*;
#(
  parameter int MAX_ATT = 16,
  parameter int ATT_W   = 5,
  parameter int TDR_W   = 10,
  parameter int BO_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [BO_W-1:0]  backoffVal,
  output logic [ATT_W-1:0] collCnt,
  output logic             backoffZero,
  output logic             stRetryFail,
  output logic             stLateColl,
  output logic             stCarrierLost,
  output logic             stDeferred,
  output logic             stOneRetry,
  output logic             stMultiRetry,
  output logic [TDR_W-1:0] stTdr
);

  localparam logic [TDR_W-1:0] TDR_MAX = {TDR_W{1'b1}};

  logic [TDR_W-1:0] tdrCnt;
  logic [BO_W-1:0]  boCnt;

  // collision distance counter, restarted per attempt, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tdrCnt <= '0;
    end else if (ctl.restartTdr) begin
      tdrCnt <= '0;
    end else if (ctl.tick && tdrCnt != TDR_MAX) begin
      tdrCnt <= tdrCnt + 1'b1;
    end
  end

  // backoff down-counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      boCnt <= '0;
    end else if (ctl.loadBackoff) begin
      boCnt <= backoffVal;
    end else if (boCnt != '0) begin
      boCnt <= boCnt - 1'b1;
    end
  end

  assign backoffZero = (boCnt == '0);

  // collision counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      collCnt <= '0;
    end else if (ctl.clrAll) begin
      collCnt <= '0;
    end else if (ctl.collide) begin
      collCnt <= collCnt + 1'b1;
    end
  end

  // status flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stRetryFail   <= 1'b0;
      stLateColl    <= 1'b0;
      stCarrierLost <= 1'b0;
      stDeferred    <= 1'b0;
      stOneRetry    <= 1'b0;
      stMultiRetry  <= 1'b0;
      stTdr         <= '0;
    end else begin
      if (ctl.clrAll) begin
        stRetryFail   <= 1'b0;
        stLateColl    <= 1'b0;
        stCarrierLost <= 1'b0;
        stDeferred    <= 1'b0;
        stOneRetry    <= 1'b0;
        stMultiRetry  <= 1'b0;
        stTdr         <= '0;
      end
      if (ctl.setDef)  stDeferred    <= 1'b1;
      if (ctl.collide) stTdr         <= tdrCnt;
      if (ctl.setLcol) stLateColl    <= 1'b1;
      if (ctl.setLcar) stCarrierLost <= 1'b1;
      if (ctl.setRtry) stRetryFail   <= 1'b1;
      if (ctl.finish) begin
        stOneRetry   <= (collCnt == ATT_W'(1));
        stMultiRetry <= (collCnt >= ATT_W'(2));
      end
    end
  end

  AST_ONE_MORE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(stOneRetry && stMultiRetry)); // R4

  AST_ATTEMPT_CAP: assert property (@(posedge clk) disable iff (!rstN)
    collCnt <= ATT_W'(MAX_ATT)); // R5

  AST_TDR_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (tdrCnt == TDR_MAX && !ctl.restartTdr) |=> (tdrCnt == TDR_MAX)); // R10

  AST_STATUS_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.clrAll || ctl.setDef || ctl.collide || ctl.setLcol || ctl.setLcar ||
      ctl.setRtry || ctl.finish)
    |=> $stable({stRetryFail, stLateColl, stCarrierLost, stDeferred,
                 stOneRetry, stMultiRetry, stTdr})); // R11

endmodule

// File: rtl/txrt_ctrl.sv
module txrt_ctrl
  import txrt_pkg::*;
#(
  parameter int MAX_ATT = 16,
  parameter int ATT_W   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txStart,
  input  logic             collision,
  input  logic             carrierOk,
  input  logic             netBusy,
  input  logic             slotDone,
  input  logic             frameEnd,
  input  logic             noRetry,
  input  logic [ATT_W-1:0] collCnt,
  input  logic             backoffZero,
  output dpCtl_t           ctl,
  output logic             xmitOn,
  output logic             retryReq,
  output logic             abortTx,
  output logic             doneTx
);

  txState_t state, stateNxt;
  logic     retryNxt, abortNxt, doneNxt;
  logic     lastAttempt;

  // this collision uses up the final permitted attempt
  assign lastAttempt = noRetry ? (collCnt == '0) : (collCnt == ATT_W'(MAX_ATT - 1));

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    retryNxt = 1'b0;
    abortNxt = 1'b0;
    doneNxt  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (txStart) begin
          ctl.clrAll = 1'b1;
          if (netBusy) begin
            ctl.setDef = 1'b1;
            stateNxt   = ST_DEFER;
          end else begin
            ctl.restartTdr = 1'b1;
            stateNxt       = ST_XMIT;
          end
        end
      end
      ST_DEFER: begin
        if (!netBusy) begin
          ctl.restartTdr = 1'b1;
          stateNxt       = ST_XMIT;
        end
      end
      ST_XMIT: begin
        ctl.tick = 1'b1;
        if (collision) begin
          if (slotDone) begin
            ctl.setLcol = 1'b1;
            abortNxt    = 1'b1;
            stateNxt    = ST_IDLE;
          end else begin
            ctl.collide = 1'b1;
            if (lastAttempt) begin
              ctl.setRtry = 1'b1;
              abortNxt    = 1'b1;
              stateNxt    = ST_IDLE;
            end else begin
              ctl.loadBackoff = 1'b1;
              retryNxt        = 1'b1;
              stateNxt        = ST_BACKOFF;
            end
          end
        end else if (!carrierOk) begin
          ctl.setLcar = 1'b1;
          abortNxt    = 1'b1;
          stateNxt    = ST_IDLE;
        end else if (frameEnd) begin
          ctl.finish = 1'b1;
          doneNxt    = 1'b1;
          stateNxt   = ST_IDLE;
        end
      end
      ST_BACKOFF: begin
        if (backoffZero) begin
          if (netBusy) begin
            ctl.setDef = 1'b1;
            stateNxt   = ST_DEFER;
          end else begin
            ctl.restartTdr = 1'b1;
            stateNxt       = ST_XMIT;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      retryReq <= 1'b0;
      abortTx  <= 1'b0;
      doneTx   <= 1'b0;
    end else begin
      state    <= stateNxt;
      retryReq <= retryNxt;
      abortTx  <= abortNxt;
      doneTx   <= doneNxt;
    end
  end

  assign xmitOn = (state == ST_XMIT);

  AST_DONE_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(doneTx && abortTx)); // R1

  AST_LATE_NO_RETRY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_XMIT && collision && slotDone) |=> (abortTx && !retryReq)); // R7

  AST_NORETRY_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_XMIT && collision && !slotDone && noRetry) |=> abortTx); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !txStart) |=> (state == ST_IDLE)); // R11

  AST_BUSY_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEFER && netBusy) |=> !xmitOn); // R2

endmodule

// File: rtl/txRetryTracker.sv
module txRetryTracker
  import txrt_pkg::*;
#(
  parameter int MAX_ATT = 16,
  parameter int TDR_W   = 10,
  parameter int BO_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txStart,
  input  logic             collision,
  input  logic             carrierOk,
  input  logic             netBusy,
  input  logic             slotDone,
  input  logic             frameEnd,
  input  logic             noRetry,
  input  logic [BO_W-1:0]  backoffVal,
  output logic             xmitOn,
  output logic             retryReq,
  output logic             abortTx,
  output logic             doneTx,
  output logic             stRetryFail,
  output logic             stLateColl,
  output logic             stCarrierLost,
  output logic             stDeferred,
  output logic             stOneRetry,
  output logic             stMultiRetry,
  output logic [TDR_W-1:0] stTdr
);

  localparam int ATT_W = $clog2(MAX_ATT + 1);

  dpCtl_t           ctl;
  logic [ATT_W-1:0] collCnt;
  logic             backoffZero;

  txrt_ctrl #(.MAX_ATT(MAX_ATT), .ATT_W(ATT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .txStart(txStart), .collision(collision),
    .carrierOk(carrierOk), .netBusy(netBusy), .slotDone(slotDone),
    .frameEnd(frameEnd), .noRetry(noRetry), .collCnt(collCnt),
    .backoffZero(backoffZero), .ctl(ctl), .xmitOn(xmitOn),
    .retryReq(retryReq), .abortTx(abortTx), .doneTx(doneTx)
  );

  txrt_data #(.MAX_ATT(MAX_ATT), .ATT_W(ATT_W), .TDR_W(TDR_W), .BO_W(BO_W)) i_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .backoffVal(backoffVal),
    .collCnt(collCnt), .backoffZero(backoffZero),
    .stRetryFail(stRetryFail), .stLateColl(stLateColl),
    .stCarrierLost(stCarrierLost), .stDeferred(stDeferred),
    .stOneRetry(stOneRetry), .stMultiRetry(stMultiRetry), .stTdr(stTdr)
  );

endmodule

// File: tb/test_txRetryTracker.sv
module test_txRetryTracker;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txStart = 1'b0, collision = 1'b0, carrierOk = 1'b1, netBusy = 1'b0;
  logic       slotDone = 1'b0, frameEnd = 1'b0, noRetry = 1'b0;
  logic [7:0] backoffVal = '0;
  logic       xmitOn, retryReq, abortTx, doneTx;
  logic       stRetryFail, stLateColl, stCarrierLost, stDeferred, stOneRetry, stMultiRetry;
  logic [9:0] stTdr;

  int nChecks = 0;
  int nErr = 0;

  always #4 clk = ~clk;

  txRetryTracker i_txRetryTracker (
    .clk(clk), .rstN(rstN), .txStart(txStart), .collision(collision),
    .carrierOk(carrierOk), .netBusy(netBusy), .slotDone(slotDone),
    .frameEnd(frameEnd), .noRetry(noRetry), .backoffVal(backoffVal),
    .xmitOn(xmitOn), .retryReq(retryReq), .abortTx(abortTx), .doneTx(doneTx),
    .stRetryFail(stRetryFail), .stLateColl(stLateColl), .stCarrierLost(stCarrierLost),
    .stDeferred(stDeferred), .stOneRetry(stOneRetry), .stMultiRetry(stMultiRetry),
    .stTdr(stTdr)
  );

  function automatic logic [15:0] statusNow();
    return {stRetryFail, stLateColl, stCarrierLost, stDeferred, stOneRetry, stMultiRetry, stTdr};
  endfunction

  // expected status: outcome 0 = sent, 1 = late collision, 2 = carrier loss
  function automatic logic [15:0] expStat(input int deferCyc, input int nColl,
                                          input int outcome, input bit nr, input int lastOff);
    int  lim  = nr ? 1 : 16;
    bit  rtry = (nColl >= lim);
    bit  ok   = !rtry && outcome == 0;
    int  tdr  = (lastOff > 1023) ? 1023 : lastOff;
    return {rtry, !rtry && outcome == 1, !rtry && outcome == 2, deferCyc > 0,
            ok && nColl == 1, ok && nColl >= 2, 10'(tdr)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doPacket(input int deferCyc, input int nCollIn, input int outcome,
                          input bit nr, input int firstOff, input bit poke);
    int lim = nr ? 1 : 16;
    int nColl = (nCollIn > lim) ? lim : nCollIn;
    int lastOff = 0;
    int off, bo, lowCnt, finalAt;
    @(negedge clk);
    txStart = 1'b1; noRetry = nr; netBusy = (deferCyc > 0);
    @(negedge clk);
    txStart = 1'b0;
    if (deferCyc == 0) begin
      chk("R11 status cleared on new packet", 32'(statusNow()), 32'd0);
    end else begin
      chk("R2 line held off while busy", 32'(xmitOn), 32'd0);
      repeat (deferCyc - 1) @(negedge clk);
      netBusy = 1'b0;
    end
    for (int a = 0; a < 17; a++) begin
      while (!xmitOn) @(negedge clk);
      if (a < nColl) begin
        off = (a == 0 && firstOff >= 0) ? firstOff : int'($urandom_range(0, 20));
        repeat (off) @(negedge clk);
        collision = 1'b1;
        bo = int'($urandom_range(0, 6));
        backoffVal = 8'(bo);
        @(negedge clk);
        collision = 1'b0;
        lastOff = off;
        if (a + 1 == lim) begin
          chk(nr ? "R6 abort after single collision" : "R5 abort at retry limit",
              32'({abortTx, retryReq}), 32'b10);
          break;
        end
        chk("R3 retry request pulse", 32'({retryReq, abortTx}), 32'b10);
        lowCnt = 0;
        while (!xmitOn) begin lowCnt++; @(negedge clk); end
        chk("R3 backoff length", 32'(lowCnt), 32'(bo + 1));
      end else begin
        finalAt = int'($urandom_range(1, 20));
        txStart = poke;
        @(negedge clk);
        txStart = 1'b0;
        repeat (finalAt - 1) @(negedge clk);
        case (outcome)
          0: frameEnd = 1'b1;
          1: begin collision = 1'b1; slotDone = 1'b1; end
          default: carrierOk = 1'b0;
        endcase
        @(negedge clk);
        frameEnd = 1'b0; collision = 1'b0; slotDone = 1'b0; carrierOk = 1'b1;
        if (outcome == 0)
          chk("R1 done pulse", 32'({doneTx, abortTx}), 32'b10);
        else if (outcome == 1)
          chk("R7 late collision aborts", 32'({abortTx, retryReq}), 32'b10);
        else
          chk("R8 carrier loss aborts", 32'({abortTx, retryReq}), 32'b10);
        break;
      end
    end
    chk("R9 R4 status bundle", 32'(statusNow()),
        32'(expStat(deferCyc, nColl, outcome, nr, lastOff)));
    repeat (3) @(negedge clk);
    chk("R11 status frozen after end", 32'(statusNow()),
        32'(expStat(deferCyc, nColl, outcome, nr, lastOff)));
    chk("R1 pulses one cycle", 32'({doneTx, abortTx, xmitOn}), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++; nChecks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    chk("R1 reset outputs low",
        32'({xmitOn, retryReq, abortTx, doneTx, statusNow()}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    doPacket(0, 0, 0, 1'b0, -1, 1'b0);      // R1 clean send
    doPacket(3, 0, 0, 1'b0, -1, 1'b0);      // R2 deferral
    doPacket(0, 1, 0, 1'b0, -1, 1'b0);      // R4 one retry
    doPacket(0, 4, 0, 1'b0, -1, 1'b0);      // R4 several retries
    doPacket(0, 15, 0, 1'b0, -1, 1'b0);     // R5 one short of limit
    doPacket(0, 16, 0, 1'b0, -1, 1'b0);     // R5 limit reached
    doPacket(0, 1, 0, 1'b1, -1, 1'b0);      // R6 retry disabled
    doPacket(0, 0, 0, 1'b1, -1, 1'b0);      // R6 no collision, sends
    doPacket(0, 2, 1, 1'b0, -1, 1'b0);      // R7 late collision
    doPacket(2, 1, 2, 1'b0, -1, 1'b0);      // R8 carrier loss
    doPacket(0, 1, 0, 1'b0, 1100, 1'b0);    // R10 saturation
    doPacket(0, 2, 0, 1'b0, 1100, 1'b0);    // R9 restart per attempt
    doPacket(0, 1, 0, 1'b0, 0, 1'b0);       // R9 collision in first cycle
    doPacket(4, 0, 0, 1'b0, -1, 1'b1);      // R11 start ignored mid-packet

    // R12 priority: collision over carrier loss and frame end, then carrier over frame end
    @(negedge clk);
    txStart = 1'b1; noRetry = 1'b0;
    @(negedge clk);
    txStart = 1'b0;
    while (!xmitOn) @(negedge clk);
    collision = 1'b1; carrierOk = 1'b0; frameEnd = 1'b1; backoffVal = 8'd0;
    @(negedge clk);
    collision = 1'b0; carrierOk = 1'b1; frameEnd = 1'b0;
    chk("R12 collision wins", 32'({retryReq, abortTx, doneTx}), 32'b100);
    while (!xmitOn) @(negedge clk);
    carrierOk = 1'b0; frameEnd = 1'b1;
    @(negedge clk);
    carrierOk = 1'b1; frameEnd = 1'b0;
    chk("R12 carrier loss over frame end", 32'({abortTx, doneTx, stCarrierLost, stOneRetry}),
        32'b1010);

    // constrained random packets
    for (int p = 0; p < 30; p++) begin
      doPacket(int'($urandom_range(0, 3)), int'($urandom_range(0, 17)),
               int'($urandom_range(0, 2)), ($urandom_range(0, 5) == 0), -1,
               ($urandom_range(0, 3) == 0));
    end

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule